// File: doc/BRIEF.md
# Locked-Mode Watchdog Timer

This block is a watchdog counter clocked by a free-running internal low-speed oscillator. It cannot be disabled. It starts counting as soon as reset is released, with its longest timeout selected. Software services it in two ways. It can write a select code into a mode register to choose a shorter timeout. It must also write a fixed key byte into an enable register often enough to restart the count before it expires.

When the count expires, or when the enable register receives any byte other than the key, the block emits a one-cycle internal reset request. It then returns to its reset state: count zero and longest timeout. The clock-source field of the mode register is locked to the internal oscillator and cannot be changed. The low-power stop indication is accepted but has no influence, so the watchdog keeps running through stop mode.

Top module: `wdt_locked`

## Requirements
- R1: After reset, `resetReq` is 0. A read with `rdSel`=0 (mode register) returns 0x1F, and a read with `rdSel`=1 (enable register) returns the constant 0xD5.
- R2: The mode-register select code in bits 2:0, value n from 0 to 7, sets the timeout to 2^(MIN_EXP+n) oscillator cycles. MIN_EXP is MAX_EXP-7, so the default is 2^11 to 2^18.
- R3: Let L be the selected timeout. If L clock edges follow the last count clear with no clearing write, `resetReq` is 1 for exactly the one cycle after the L-th edge. At that same edge the select code returns to 7 and the count restarts from zero. Reset release counts as a clear.
- R4: A write with `wrSel`=1 and data 0xAC clears the count, and the timeout is then measured again from that edge.
- R5: A write with `wrSel`=0 clears the count and loads data bits 2:0 as the new select code.
- R6: Data bits 7:3 of a mode-register write are ignored. The clock-source bits 4:3 always read back as 1, and bits 7:5 read back as 0.
- R7: A write with `wrSel`=1 and any data other than 0xAC makes `resetReq` 1 in the next cycle. It also returns the select code to 7 and clears the count.
- R8: `stopMode` has no effect: the count, the timeout and `resetReq` behave the same whether it is 0 or 1.
- R9: A key write or a mode write made at the edge where the count would expire takes priority. No reset request is produced, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal low-speed oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe, one byte per cycle |
| wrSel | input | 1 | Write target: 0 mode register, 1 enable register |
| wrData | input | 8 | Write data byte |
| rdSel | input | 1 | Read target: 0 mode register, 1 enable register |
| rdData | output | 8 | Read data byte |
| stopMode | input | 1 | Low-power stop indication (ignored) |
| resetReq | output | 1 | One-cycle internal reset request |

## Verification
The bench targets the edge where the count expires. A key or mode write there must suppress the request. A design that lets the expiry win would reset a system that was serviced in time. An off-by-one in the timeout comparison would shift the pulse by one cycle against the independent cycle model. Bad-key bytes are checked for an immediate request and a forced return to the longest timeout. A design that only clears the count would leave the short timeout selected. Random mode bytes with the upper bits set catch a design that lets the locked clock-source bits be written or read back wrongly. Random toggling of `stopMode` during long idle stretches catches any gating of the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W = 3;
  localparam logic [7:0] KEY_BYTE = 8'hAC;
  localparam logic [7:0] ENABLE_READ = 8'hD5;

  typedef struct packed {
    logic clrCnt;
    logic loadMode;
    logic forceMax;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrData,
  input  logic        atLimit,
  output wdtStrobes_t strobes,
  output logic        resetReq
);
  logic keyOk, keyBad, modeWr, expire, forceReset;

  always_comb begin
    keyOk      = wrEn && wrSel && (wrData == KEY_BYTE);
    keyBad     = wrEn && wrSel && (wrData != KEY_BYTE);
    modeWr     = wrEn && !wrSel;
    expire     = atLimit && !wrEn;
    forceReset = keyBad || expire;
    strobes.forceMax = forceReset;
    strobes.loadMode = modeWr;
    strobes.clrCnt   = keyOk || modeWr || forceReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= forceReset;
  end

  AST_BAD_KEY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    keyBad |=> resetReq); // R7
  AST_SERVICE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (keyOk || modeWr) |=> !resetReq); // R9
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int MAX_EXP = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobes_t      strobes,
  input  logic [SEL_W-1:0] modeIn,
  input  logic             rdSel,
  input  logic             stopMode,
  output logic             atLimit,
  output logic [7:0]       rdData
);
  localparam int CNT_W   = MAX_EXP;
  localparam int MIN_EXP = MAX_EXP - (2**SEL_W - 1);
  localparam int PAD_W   = 8 - SEL_W - 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termVal;
  logic [SEL_W-1:0] modeSel;

  always_comb begin
    termVal = ~({CNT_W{1'b1}} << (MIN_EXP + int'(modeSel)));
    atLimit = (cnt == termVal);
    rdData  = rdSel ? ENABLE_READ : {{PAD_W{1'b0}}, 2'b11, modeSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      modeSel <= '1;
    end else begin
      if (strobes.clrCnt) cnt <= '0;
      else                cnt <= cnt + 1'b1;
      if (strobes.forceMax)      modeSel <= '1;
      else if (strobes.loadMode) modeSel <= modeIn;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termVal); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCnt |=> (cnt == '0)); // R4
  AST_FORCE_MAXSEL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceMax |=> (modeSel == '1)); // R3
  AST_STOP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !strobes.clrCnt) |=> (cnt == $past(cnt) + 1'b1)); // R8
endmodule

// File: rtl/wdt_locked.sv
module wdt_locked
  import wdt_pkg::*;
#(
  parameter int MAX_EXP = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       rdSel,
  output logic [7:0] rdData,
  input  logic       stopMode,
  output logic       resetReq
);
  wdtStrobes_t strobes;
  logic        atLimit;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .atLimit(atLimit), .strobes(strobes), .resetReq(resetReq)
  );

  wdt_datapath #(.MAX_EXP(MAX_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeIn(wrData[SEL_W-1:0]),
    .rdSel(rdSel), .stopMode(stopMode), .atLimit(atLimit), .rdData(rdData)
  );
endmodule

// File: tb/wdt_locked_tb.sv
module wdt_locked_tb;
  localparam int MAX_EXP = 12;
  localparam int MIN_EXP = MAX_EXP - 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0, stopMode = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic resetReq;

  int nChecks = 0;
  int nFails = 0;
  int expCnt = 0;
  int expSel = 7;
  bit expReq = 1'b0;

  always #2.5 clk = ~clk;

  wdt_locked #(.MAX_EXP(MAX_EXP)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .stopMode(stopMode), .resetReq(resetReq)
  );

  function automatic int limitOf(int sel);
    return 1 << (MIN_EXP + sel);
  endfunction

  function automatic logic [7:0] expRead(bit sel, int mode);
    return sel ? 8'hD5 : (8'h18 | 8'(mode));
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, model the posedge, compare at the next negedge.
  task automatic step(bit we, bit ws, logic [7:0] d, bit stp, string tag);
    wrEn = we; wrSel = ws; wrData = d; stopMode = stp; rdSel = 1'($urandom);
    @(posedge clk);
    if (we && ws && d != 8'hAC) begin expReq = 1; expCnt = 0; expSel = 7; end
    else if (we && ws) begin expReq = 0; expCnt = 0; end
    else if (we) begin expReq = 0; expCnt = 0; expSel = int'(d[2:0]); end
    else if (expCnt == limitOf(expSel) - 1) begin expReq = 1; expCnt = 0; expSel = 7; end
    else begin expReq = 0; expCnt++; end
    @(negedge clk);
    wrEn = 1'b0;
    check(tag, {7'd0, resetReq}, {7'd0, expReq}, "resetReq");
    check(tag, rdData, expRead(rdSel, expSel), "rdData");
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'($urandom), tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen at the ports
    rdSel = 1'b0; #1;
    check("R1", rdData, 8'h1F, "mode read");
    rdSel = 1'b1; #1;
    check("R1", rdData, 8'hD5, "enable read");
    check("R1", {7'd0, resetReq}, 8'h00, "resetReq");
    // R3: longest timeout from reset release, stop mode toggling (R8)
    idle(limitOf(7) + 3, "R3");
    // R2, R5, R6: each select code, upper data bits random
    for (int s = 0; s < 8; s++) begin
      step(1'b1, 1'b0, {5'($urandom), 3'(s)}, 1'b0, "R5");
      idle(limitOf(s) + 2, "R2");
    end
    // R4, R8: periodic key servicing prevents any request
    step(1'b1, 1'b0, 8'hFA, 1'b1, "R6");
    for (int k = 0; k < 20; k++) begin
      idle(60 + ($urandom % 60), "R8");
      step(1'b1, 1'b1, 8'hAC, 1'($urandom), "R4");
    end
    // R7: bad key bytes
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 8'h00, 1'b0, "R5");
      idle(5, "R7");
      step(1'b1, 1'b1, 8'hAC ^ (8'd1 << (k % 8)), 1'b0, "R7");
      idle(3, "R7");
    end
    // R9: service write exactly at the expiring edge
    step(1'b1, 1'b0, 8'h00, 1'b0, "R5");
    idle(limitOf(0) - 1, "R9");
    step(1'b1, 1'b1, 8'hAC, 1'b0, "R9");
    idle(limitOf(0) - 1, "R9");
    step(1'b1, 1'b0, 8'h01, 1'b0, "R9");
    idle(limitOf(1) + 2, "R9");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      if (r < 3) step(1'b1, 1'b1, 8'hAC, 1'($urandom), "R4");
      else if (r < 4) step(1'b1, 1'b0, 8'($urandom), 1'($urandom), "R5");
      else if (r == 4 && ($urandom % 4) == 0) step(1'b1, 1'b1, 8'($urandom), 1'b0, "R7");
      else step(1'b0, 1'b0, 8'($urandom), 1'($urandom), "R3");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule